// File: doc/BRIEF.md
# Region-Register Address Translator

This block turns a virtual address into a physical address. The first level of translation is not a table in memory. It is three base/length register pairs held on chip. The top two bits of the virtual address pick a region. Two regions belong to the running process, one belongs to the kernel, and the fourth encoding is reserved.

The kernel pair points at its page table with a physical address. A kernel address therefore costs a single memory read.

Each process pair holds the virtual address of its page table, and that address lies in kernel space. Before the process entry can be read, its address must first be translated through the kernel table. A process address therefore costs two reads.

Software rewrites the two process pairs whenever it switches context. The kernel pair stays as it is. Every fault that can be decided from the registers alone is reported without touching memory.

Top module: `region_xlate`

## Requirements
- R1: Address bits [31:30] select the region: 00 is process region A (pair 0), 01 is process region B (pair 1), 10 is the kernel region (pair 2), and 11 is reserved. A reserved address returns an access fault and issues no memory read.
- R2: `rsp_fault` is coded as 0 for success, 1 for a length fault, 2 for an access fault and 3 for a translation fault. `rsp_pa` carries the result only when the code is 0.
- R3: A user-mode request (`req_kmode`=0) to the kernel region returns an access fault with no memory read. A kernel-mode request may use all three regions.
- R4: The page number is bits [29:9] and the offset is bits [8:0]. If the page number is equal to or above the region's length register, the result is a length fault with no memory read. A length of 0 therefore faults every access.
- R5: A kernel-region request makes exactly one read, at kernel_base + 4*page. If that entry is valid, the physical address is {entry[20:0], va[8:0]}.
- R6: A process-region request forms a table address T = base + 4*page. If T[29:9] is equal to or above the kernel length, the result is a length fault with no read. Otherwise the walk reads the kernel entry at kernel_base + 4*T[29:9], then reads the process entry at {kernel_entry[20:0], T[8:0]}, and builds the result from the second entry.
- R7: In an entry, bit 31 is the valid flag and bits [20:0] are the frame number. Bits [30:21] are ignored. An invalid entry at either read returns a translation fault and ends the walk with no further read.
- R8: A write with `cfg_sel` of 0, 1 or 2 loads both the base and the length of that pair. A write with `cfg_sel`=3 is ignored. Rewriting a process pair leaves the kernel pair unchanged, and later requests use the new values.
- R9: In reset, `rsp_valid` and `mem_rd` are low and `req_ready` is high. `req_ready` is low while a walk is running. `mem_rd` stays high, with `mem_addr` held steady, until `mem_rvalid`. `rsp_valid` is a pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Pair write strobe |
| cfg_sel | input | 2 | Pair index (0, 1, 2; 3 ignored) |
| cfg_base | input | 32 | Table base: virtual for pairs 0 and 1, physical for pair 2 |
| cfg_len | input | 22 | Region length in pages |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_kmode | input | 1 | 1 = kernel mode |
| mem_rd | output | 1 | Entry read request, held until answered |
| mem_addr | output | 30 | Physical byte address of the entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 2 | Fault code |
| rsp_pa | output | 30 | Physical address |

## Verification
The bench counts the entry reads for every request, so a fault raised after a read, or a walk that reads past an invalid entry, shows up as a wrong read count. Two cases need a process table that starts just below a kernel page boundary: one checks that the nested translation uses the page of the table address and not the page of the base, and the other checks that the nested length check applies to that page. A junk bit placed in the ignored field of a kernel entry exposes a design that decodes too wide a frame number. Writes to pair index 3, and rewrites of the process pairs, are followed by a kernel lookup; a design that corrupted the kernel pair would return a different address or a fault.

// File: rtl/region_xlate.sv
module region_xlate #(
  parameter int VA_W  = 32,
  parameter int OFS_W = 9,
  parameter int PFN_W = 21,
  parameter int PTE_W = 32,
  parameter int LEN_W = VA_W - 2 - OFS_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [VA_W-1:0]    cfg_base,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_kmode,
  output logic               mem_rd,
  output logic [PFN_W+OFS_W-1:0] mem_addr,
  input  logic               mem_rvalid,
  input  logic [PTE_W-1:0]   mem_rdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_fault,
  output logic [PFN_W+OFS_W-1:0] rsp_pa
);
  localparam int VPN_W = VA_W - 2 - OFS_W;
  localparam int PA_W  = PFN_W + OFS_W;
  localparam logic [1:0] F_OK = 2'd0, F_LEN = 2'd1, F_ACC = 2'd2, F_XLT = 2'd3;
  localparam logic [1:0] KRN = 2'd2;

  logic [VA_W-1:0]  base_q [3];
  logic [LEN_W-1:0] len_q  [3];
  logic             busy, nested;
  logic [OFS_W-1:0] ofs_q, tofs_q;

  logic [1:0]       rgn, ri;
  logic [VPN_W-1:0] vpn, tvpn, kidx;
  logic [VA_W-1:0]  tva;
  logic [PA_W-1:0]  first_addr;
  logic [1:0]       fault_now;
  logic             pte_ok;
  logic [PFN_W-1:0] pfn;

  assign rgn  = req_va[VA_W-1 -: 2];
  assign ri   = (rgn == 2'd3) ? 2'd0 : rgn;
  assign vpn  = req_va[OFS_W +: VPN_W];
  assign tva  = base_q[ri] + VA_W'({vpn, 2'b00});
  assign tvpn = tva[OFS_W +: VPN_W];
  assign kidx = (rgn == KRN) ? vpn : tvpn;
  assign first_addr = base_q[KRN][PA_W-1:0] + PA_W'({kidx, 2'b00});
  assign pte_ok = mem_rdata[PTE_W-1];
  assign pfn    = mem_rdata[PFN_W-1:0];

  assign req_ready = !busy;
  assign mem_rd    = busy;

  always_comb begin
    if (rgn == 2'd3 || (rgn == KRN && !req_kmode)) fault_now = F_ACC;
    else if ({1'b0, vpn} >= len_q[ri])             fault_now = F_LEN;
    else if (rgn != KRN && {1'b0, tvpn} >= len_q[KRN]) fault_now = F_LEN;
    else                                           fault_now = F_OK;
  end

  logic unused;
  assign unused = ^{tva[VA_W-1:OFS_W+VPN_W], mem_rdata[PTE_W-2:PFN_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
      busy      <= 1'b0;
      nested    <= 1'b0;
      ofs_q     <= '0;
      tofs_q    <= '0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= F_OK;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        if (cfg_we && cfg_sel == i[1:0]) begin
          base_q[i] <= cfg_base;
          len_q[i]  <= cfg_len;
        end
      end
      if (!busy && req_valid) begin
        if (fault_now != F_OK) begin
          rsp_valid <= 1'b1;
          rsp_fault <= fault_now;
          rsp_pa    <= '0;
        end else begin
          busy     <= 1'b1;
          nested   <= (rgn != KRN);
          mem_addr <= first_addr;
          ofs_q    <= req_va[OFS_W-1:0];
          tofs_q   <= tva[OFS_W-1:0];
        end
      end else if (busy && mem_rvalid) begin
        if (!pte_ok) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_fault <= F_XLT;
          rsp_pa    <= '0;
        end else if (nested) begin
          nested   <= 1'b0;
          mem_addr <= {pfn, tofs_q};
        end else begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_fault <= F_OK;
          rsp_pa    <= {pfn, ofs_q};
        end
      end
    end
  end
endmodule

module region_xlate_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            req_kmode,
  input logic            mem_rd,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_rvalid,
  input logic            rsp_valid,
  input logic [1:0]      rsp_fault
);
  a_r1_reserved_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_va[VA_W-1 -: 2] == 2'b11
    |=> rsp_valid && rsp_fault == 2'd2 && !mem_rd);

  a_r3_user_kernel_denied: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_kmode && req_va[VA_W-1 -: 2] == 2'b10
    |=> rsp_valid && rsp_fault == 2'd2 && !mem_rd);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);

  a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_rvalid |=> mem_rd && $stable(mem_addr));

  a_r9_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  a_r2_success_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'd0 |-> $past(mem_rvalid) && $past(mem_rd));
endmodule

bind region_xlate region_xlate_chk #(.VA_W(VA_W), .PA_W(PFN_W + OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_kmode(req_kmode), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
);

// File: tb/sim_region_xlate.sv
module sim_region_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT = 2;
  localparam int NV = 11;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_base = 0;
  logic [21:0] cfg_len = 0;
  logic        req_valid = 0, req_kmode = 0;
  logic [31:0] req_va = 0;
  logic        req_ready, mem_rd, rsp_valid;
  logic [29:0] mem_addr, rsp_pa;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic [1:0]  rsp_fault;

  int nchk = 0, nfail = 0, nreads = 0, rdcnt = 0;
  logic [31:0] mem [logic [29:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  region_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .req_kmode(req_kmode),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 0; rdcnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 0;
    end else if (mem_rd) begin
      if (rdcnt == MEM_LAT) begin
        mem_rvalid = 1;
        mem_rdata  = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        nreads++;
        rdcnt = 0;
      end else rdcnt++;
    end else rdcnt = 0;
  end

  // {kmode, va, fault, reads, pa}
  localparam logic [66:0] VEC [NV] = '{
    {1'b1, 32'h8000_05F0, 2'd0, 2'd1, 30'h0002_05F0},
    {1'b0, 32'h8000_05F0, 2'd2, 2'd0, 30'h0},
    {1'b1, 32'h8000_2000, 2'd1, 2'd0, 30'h0},
    {1'b1, 32'h8000_1000, 2'd3, 2'd1, 30'h0},
    {1'b0, 32'h0000_0A07, 2'd0, 2'd2, 30'h0008_0A07},
    {1'b0, 32'h0000_0C00, 2'd3, 2'd2, 30'h0},
    {1'b0, 32'h0000_1000, 2'd1, 2'd0, 30'h0},
    {1'b0, 32'h4000_0000, 2'd3, 2'd1, 30'h0},
    {1'b0, 32'h4000_0800, 2'd1, 2'd0, 30'h0},
    {1'b1, 32'hC000_0000, 2'd2, 2'd0, 30'h0},
    {1'b1, 32'h0000_01FF, 2'd0, 2'd2, 30'h0008_01FF}
  };
  string VTAG [NV] = '{"R5", "R3", "R4", "R7", "R6", "R7", "R4", "R7", "R4", "R1", "R3"};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, logic [31:0] base, logic [21:0] len);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_base = base; cfg_len = len;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xlate(string tag, logic k, logic [31:0] va,
                       logic [1:0] ef, int er, logic [29:0] epa);
    int t = 0;
    @(negedge clk);
    nreads = 0;
    req_valid = 1; req_va = va; req_kmode = k;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk({tag, " response"}, {31'b0, rsp_valid}, 32'd1);
    chk({tag, " fault"}, {30'b0, rsp_fault}, {30'b0, ef});
    chk({tag, " reads"}, nreads, er);
    if (ef == 2'd0) chk({tag, " pa"}, {2'b0, rsp_pa}, {2'b0, epa});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[30'h10000 + 4*i] = 32'h8000_0100 + i;
    mem[30'h10008] = 32'h8200_0102;
    for (int j = 0; j < 6; j++) mem[30'h20600 + 4*j] = 32'h8000_0400 + j;
    mem[30'h20800] = 32'h8000_07AA;

    repeat (3) @(negedge clk);
    chk("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R9 reset mem_rd", {31'b0, mem_rd}, 32'd0);
    chk("R9 reset ready", {31'b0, req_ready}, 32'd1);
    rst_n = 1;

    cfg(2'd2, 32'h0001_0000, 22'd16);
    cfg(2'd0, 32'h8000_0600, 22'd8);
    cfg(2'd1, 32'h8000_1000, 22'd4);

    for (int i = 0; i < NV; i++)
      xlate(VTAG[i], VEC[i][66], VEC[i][65:34], VEC[i][33:32],
            int'(VEC[i][31:30]), VEC[i][29:0]);

    // R8: writes to index 3 are ignored
    cfg(2'd3, 32'hFFFF_FFFF, 22'd0);
    xlate("R8 sel3 ignored", 1'b1, 32'h8000_05F0, 2'd0, 1, 30'h0002_05F0);

    // R6/R8: context switch, table straddles kernel page boundary
    cfg(2'd0, 32'h8000_07F8, 22'd8);
    xlate("R6 boundary", 1'b0, 32'h0000_0433, 2'd0, 2, 30'h000F_5433);
    xlate("R8 kernel kept", 1'b1, 32'h8000_05F0, 2'd0, 1, 30'h0002_05F0);

    // R6: nested page beyond kernel length
    cfg(2'd1, 32'h8000_4000, 22'd4);
    xlate("R6 nested length", 1'b0, 32'h4000_0000, 2'd1, 0, 30'h0);

    // R4: zero length faults everything
    cfg(2'd1, 32'h8000_0600, 22'd0);
    xlate("R4 zero length", 1'b0, 32'h4000_0000, 2'd1, 0, 30'h0);

    // R9: single-cycle response pulse
    @(negedge clk);
    chk("R9 pulse", {31'b0, rsp_valid}, 32'd0);
    chk("R9 idle", {31'b0, req_ready}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule